// File: doc/BRIEF.md
# Tiled-Aperture Fence Register File

This block holds a bank of fence entries. Each entry marks one tiled window inside a linear 32-bit graphics address space, together with the tiling layout (X or Y) and an encoded row pitch. Software programs an entry through a plain 32-bit register bus. The 64-bit entry is split across two words: the low word carries the start page, pitch, Y-select and valid bit, and the high word carries the inclusive last page of the window.

The valid bit sits in the low word. A writer can therefore follow a safe three-step update: clear the low word, write the high word, then write the low word with valid set. A half-written entry never takes part in matching. Every low-word write can be read back straight away, so the writer can confirm that each step has landed before it issues the next one.

A lookup stream takes an access address and returns, one cycle later, whether the address falls inside a valid window. The result carries the index of the winning entry, its tiling mode, its pitch, an overlap flag and the original address. Both sides of the lookup use valid/ready. An accepted request produces a result on the next cycle. While the consumer holds `res_ready` low, the result stays unchanged and no new request is taken.

Top module: `tile_fence_bank`

## Requirements
- R1: After reset every entry reads back as zero, no lookup hits, `res_valid` is 0 and `lk_ready` is 1.
- R2: The low word of entry i sits at register offset 8·i. Its layout is bits [31:12] start page, [11:2] pitch code ((stride/128)−1), bit 1 Y-tiling select (1 = Y, 0 = X) and bit 0 valid. A write is stored whole and reads back unchanged from the next cycle.
- R3: The high word of entry i sits at offset 8·i+4. Bits [31:12] hold the inclusive last page of the window. Bits [11:0] are not stored and read back as zero.
- R4: A register address at or beyond 8·NUM_FENCES, or one whose bits [1:0] are not zero, is unmapped. It reads as zero, and a write to it changes no entry.
- R5: An address hits an entry when the entry's valid bit is 1 and start page ≤ address[31:12] ≤ last page. An entry with valid 0 never hits, whatever its range.
- R6: When several entries match, the lowest index is reported and `res_overlap` is 1. `res_overlap` is 0 when at most one entry matches.
- R7: On a hit, `res_ytile` and `res_pitch` are the winning entry's Y bit and pitch code. On a miss, `res_index`, `res_ytile`, `res_pitch` and `res_overlap` are all zero.
- R8: A lookup is accepted when `lk_valid` and `lk_ready` are both 1. Its result appears with `res_valid` = 1 on the next cycle, with `res_addr` equal to the accepted address.
- R9: `lk_ready` is 1 exactly when `res_valid` is 0 or `res_ready` is 1. While `res_valid` is 1 and `res_ready` is 0, every result output holds its value.
- R10: Clearing the low word of an entry removes it from matching for every lookup accepted after the write cycle. The entry's high word is left as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset (read and write) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be accepted |
| lk_addr | input | 32 | Address to look up |
| res_valid | output | 1 | Lookup result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_addr | output | 32 | Address that produced this result |
| res_hit | output | 1 | Address lies inside a valid entry |
| res_index | output | IW | Index of the winning entry |
| res_ytile | output | 1 | Winning entry uses Y tiling |
| res_pitch | output | 10 | Winning entry's pitch code |
| res_overlap | output | 1 | More than one entry matched |

## Verification
The assertions watch several behaviours on every cycle. They check the handshake timing: an accepted request becomes a result one cycle later, and the result holds steady under back-pressure. They also check that a miss result has zeroed fields, that a reported hit always points at a valid entry, that an overlap is never flagged without a hit, and that each low-word write lands intact. Other behaviours need chosen entry contents and addresses, so only the bench scenarios show them. These are the exact page-boundary decisions at the first and last byte of a window, the choice of the lowest index inside an overlapping range, the exclusion of an entry whose range is programmed but whose valid bit is clear, the inertness of misaligned and out-of-map register offsets, and the effect of clearing a low word.

// File: rtl/fence_pkg.sv
package fence_pkg;
  localparam int WORD_W   = 32;
  localparam int PAGE_LSB = 12;
  localparam int PAGE_W   = WORD_W - PAGE_LSB;
  localparam int PITCH_W  = 10;

  // Low word: {start_pg, pitch, ytile, vld}; high word: {end_pg, 12'b0}
  typedef struct packed {
    logic [PAGE_W-1:0]  start_pg;
    logic [PITCH_W-1:0] pitch;
    logic               ytile;
    logic               vld;
  } lo_word_t;

  typedef struct packed {
    lo_word_t          lo;
    logic [PAGE_W-1:0] end_pg;
  } fence_ent_t;
endpackage

// File: rtl/fence_regs.sv
module fence_regs
  import fence_pkg::*;
#(
  parameter int NUM_FENCES = 16,
  parameter int REG_AW     = 8,
  localparam int IW        = $clog2(NUM_FENCES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output fence_ent_t        ents [NUM_FENCES]
);
  localparam int MAP_SPAN = NUM_FENCES * 8;

  logic          mapped;
  logic          sel_hi;
  logic [IW-1:0] sel_idx;
  logic          unused_hi_lsbs;

  assign mapped         = (int'(reg_addr) < MAP_SPAN) && (reg_addr[1:0] == 2'b00);
  assign sel_hi         = reg_addr[2];
  assign sel_idx        = reg_addr[IW+2:3];
  assign unused_hi_lsbs = ^reg_wdata[PAGE_LSB-1:0];

  for (genvar g = 0; g < NUM_FENCES; g++) begin : g_ent
    logic hit_here;
    assign hit_here = reg_wr && mapped && (sel_idx == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ents[g] <= '0;
      end else if (hit_here) begin
        if (sel_hi) ents[g].end_pg <= reg_wdata[WORD_W-1:PAGE_LSB];
        else        ents[g].lo     <= lo_word_t'(reg_wdata);
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (mapped) begin
      if (sel_hi) reg_rdata = {ents[sel_idx].end_pg, {PAGE_LSB{1'b0}}};
      else        reg_rdata = WORD_W'(ents[sel_idx].lo);
    end
  end

  // R2: a mapped low-word write is visible intact on the next cycle
  assert_lo_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && mapped && !sel_hi) |=> (WORD_W'(ents[$past(sel_idx)].lo) == $past(reg_wdata)));

  // R3: the high-word readback never shows its low 12 bits
  assert_hi_lsbs_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mapped && sel_hi) |-> (reg_rdata[PAGE_LSB-1:0] == '0));
endmodule

// File: rtl/fence_match.sv
module fence_match
  import fence_pkg::*;
#(
  parameter int NUM_FENCES = 16,
  localparam int IW        = $clog2(NUM_FENCES)
) (
  input  fence_ent_t         ents [NUM_FENCES],
  input  logic [PAGE_W-1:0]  page,
  output logic               hit,
  output logic [IW-1:0]      idx,
  output logic               ytile,
  output logic [PITCH_W-1:0] pitch,
  output logic               overlap
);
  logic [NUM_FENCES-1:0] m;

  for (genvar g = 0; g < NUM_FENCES; g++) begin : g_cmp
    assign m[g] = ents[g].lo.vld
               && (page >= ents[g].lo.start_pg)
               && (page <= ents[g].end_pg);
  end

  always_comb begin
    idx = '0;
    for (int i = NUM_FENCES - 1; i >= 0; i--) begin
      if (m[i]) idx = IW'(i);
    end
  end

  assign hit     = |m;
  assign overlap = (m & (m - 1'b1)) != '0;
  assign ytile   = hit ? ents[idx].lo.ytile : 1'b0;
  assign pitch   = hit ? ents[idx].lo.pitch : '0;
endmodule

// File: rtl/fence_lookup_pipe.sv
module fence_lookup_pipe
  import fence_pkg::*;
#(
  parameter int IW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [WORD_W-1:0]  in_addr,
  input  logic               in_hit,
  input  logic [IW-1:0]      in_idx,
  input  logic               in_ytile,
  input  logic [PITCH_W-1:0] in_pitch,
  input  logic               in_overlap,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [WORD_W-1:0]  out_addr,
  output logic               out_hit,
  output logic [IW-1:0]      out_idx,
  output logic               out_ytile,
  output logic [PITCH_W-1:0] out_pitch,
  output logic               out_overlap
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_addr    <= '0;
      out_hit     <= 1'b0;
      out_idx     <= '0;
      out_ytile   <= 1'b0;
      out_pitch   <= '0;
      out_overlap <= 1'b0;
    end else if (take) begin
      out_valid   <= 1'b1;
      out_addr    <= in_addr;
      out_hit     <= in_hit;
      out_idx     <= in_idx;
      out_ytile   <= in_ytile;
      out_pitch   <= in_pitch;
      out_overlap <= in_overlap;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  // R8: accepted request yields its result one cycle later
  assert_accept_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_addr == $past(in_addr)));

  // R9: stalled result holds steady
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_hit)
      && $stable(out_idx) && $stable(out_ytile) && $stable(out_pitch) && $stable(out_overlap)));

  // R7: a miss carries zeroed fields
  assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (out_idx == '0 && !out_ytile && out_pitch == '0 && !out_overlap));
endmodule

// File: rtl/tile_fence_bank.sv
module tile_fence_bank
  import fence_pkg::*;
#(
  parameter int NUM_FENCES = 16,
  parameter int REG_AW     = 8,
  localparam int IW        = $clog2(NUM_FENCES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               lk_valid,
  output logic               lk_ready,
  input  logic [31:0]        lk_addr,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [31:0]        res_addr,
  output logic               res_hit,
  output logic [IW-1:0]      res_index,
  output logic               res_ytile,
  output logic [9:0]         res_pitch,
  output logic               res_overlap
);
  fence_ent_t         ents [NUM_FENCES];
  logic               m_hit, m_ytile, m_overlap;
  logic [IW-1:0]      m_idx;
  logic [PITCH_W-1:0] m_pitch;

  fence_regs #(.NUM_FENCES(NUM_FENCES), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ents(ents)
  );

  fence_match #(.NUM_FENCES(NUM_FENCES)) u_match (
    .ents(ents), .page(lk_addr[WORD_W-1:PAGE_LSB]), .hit(m_hit), .idx(m_idx),
    .ytile(m_ytile), .pitch(m_pitch), .overlap(m_overlap)
  );

  fence_lookup_pipe #(.IW(IW)) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .in_valid(lk_valid), .in_ready(lk_ready), .in_addr(lk_addr),
    .in_hit(m_hit), .in_idx(m_idx), .in_ytile(m_ytile), .in_pitch(m_pitch),
    .in_overlap(m_overlap),
    .out_valid(res_valid), .out_ready(res_ready), .out_addr(res_addr),
    .out_hit(res_hit), .out_idx(res_index), .out_ytile(res_ytile),
    .out_pitch(res_pitch), .out_overlap(res_overlap)
  );

  // R5: a reported match always names a valid entry covering the page
  assert_hit_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    m_hit |-> (ents[m_idx].lo.vld
               && lk_addr[WORD_W-1:PAGE_LSB] >= ents[m_idx].lo.start_pg
               && lk_addr[WORD_W-1:PAGE_LSB] <= ents[m_idx].end_pg));

  // R6: overlap implies a hit
  assert_overlap_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    m_overlap |-> m_hit);
endmodule

// File: tb/test_tile_fence_bank.sv
module test_tile_fence_bank;
  localparam int NF = 16;
  localparam int IW = $clog2(NF);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [31:0] lk_addr = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [31:0] res_addr;
  logic        res_hit;
  logic [IW-1:0] res_index;
  logic        res_ytile;
  logic [9:0]  res_pitch;
  logic        res_overlap;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  tile_fence_bank #(.NUM_FENCES(NF), .REG_AW(8)) i_tile_fence_bank (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
    .lk_ready(lk_ready), .lk_addr(lk_addr), .res_valid(res_valid),
    .res_ready(res_ready), .res_addr(res_addr), .res_hit(res_hit),
    .res_index(res_index), .res_ytile(res_ytile), .res_pitch(res_pitch),
    .res_overlap(res_overlap)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic        hit;
    logic [3:0]  idx;
    logic        y;
    logic [9:0]  pitch;
    logic        ovl;
  } vec_t;

  // Entries: 0 = pages 0x100..0x103 X pitch 3; 2 = page 0x200 Y pitch 7;
  // 5 = pages 0x102..0x108 Y pitch 0x3FF; 1 = range 0x300 but not valid
  localparam vec_t VECS [12] = '{
    '{32'h000F_FFFC, 1'b0, 4'd0, 1'b0, 10'd0,   1'b0},
    '{32'h0010_0000, 1'b1, 4'd0, 1'b0, 10'd3,   1'b0},
    '{32'h0010_1FFF, 1'b1, 4'd0, 1'b0, 10'd3,   1'b0},
    '{32'h0010_2000, 1'b1, 4'd0, 1'b0, 10'd3,   1'b1},
    '{32'h0010_3FFF, 1'b1, 4'd0, 1'b0, 10'd3,   1'b1},
    '{32'h0010_4000, 1'b1, 4'd5, 1'b1, 10'h3FF, 1'b0},
    '{32'h0010_8FFF, 1'b1, 4'd5, 1'b1, 10'h3FF, 1'b0},
    '{32'h0010_9000, 1'b0, 4'd0, 1'b0, 10'd0,   1'b0},
    '{32'h0020_0000, 1'b1, 4'd2, 1'b1, 10'd7,   1'b0},
    '{32'h0020_0FFF, 1'b1, 4'd2, 1'b1, 10'd7,   1'b0},
    '{32'h0020_1000, 1'b0, 4'd0, 1'b0, 10'd0,   1'b0},
    '{32'h0030_0010, 1'b0, 4'd0, 1'b0, 10'd0,   1'b0}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic look(input vec_t v, input string tag);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = v.addr;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(res_valid && res_addr == v.addr, {tag, " R8 valid/addr"}, res_addr, v.addr);
    chk(res_hit == v.hit, {tag, " R5 hit"}, 32'(res_hit), 32'(v.hit));
    chk(res_index == v.idx && res_overlap == v.ovl, {tag, " R6 index/overlap"},
        {27'd0, res_overlap, res_index}, {27'd0, v.ovl, v.idx});
    chk(res_ytile == v.y && res_pitch == v.pitch, {tag, " R7 tiling/pitch"},
        {21'd0, res_ytile, res_pitch}, {21'd0, v.y, v.pitch});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    #1;
    chk(!res_valid && lk_ready, "R1 res_valid/lk_ready", {30'd0, res_valid, lk_ready}, 32'd1);
    rd_chk(8'h00, 32'h0, "R1 entry0 low");
    rd_chk(8'h2C, 32'h0, "R1 entry5 high");
    look('{32'h0000_0000, 1'b0, 4'd0, 1'b0, 10'd0, 1'b0}, "R1 lookup after reset");

    // program with the disable / high / low sequence
    wr(8'h00, 32'h0);  wr(8'h04, 32'h0010_3000); wr(8'h00, 32'h0010_000D);
    wr(8'h10, 32'h0);  wr(8'h14, 32'h0020_0000); wr(8'h10, 32'h0020_001F);
    wr(8'h28, 32'h0);  wr(8'h2C, 32'h0010_8ABC); wr(8'h28, 32'h0010_2FFF);
    wr(8'h0C, 32'h0030_0000);

    // R2 / R3: readback
    rd_chk(8'h00, 32'h0010_000D, "R2 entry0 low");
    rd_chk(8'h28, 32'h0010_2FFF, "R2 entry5 low");
    rd_chk(8'h2C, 32'h0010_8000, "R3 entry5 high lsbs dropped");

    // table walk: R5 R6 R7 R8
    for (int i = 0; i < 12; i++) look(VECS[i], $sformatf("vec%0d", i));

    // R4: unmapped and misaligned
    wr(8'h80, 32'hFFFF_FFFF);
    rd_chk(8'h80, 32'h0, "R4 out-of-map read");
    wr(8'h01, 32'hFFFF_FFFF);
    rd_chk(8'h00, 32'h0010_000D, "R4 misaligned write ignored");
    rd_chk(8'h01, 32'h0, "R4 misaligned read");
    look('{32'hFFFF_F000, 1'b0, 4'd0, 1'b0, 10'd0, 1'b0}, "R4 no entry created");

    // R9: back-pressure
    @(negedge clk);
    res_ready = 1'b0; lk_valid = 1'b1; lk_addr = 32'h0020_0000;
    @(negedge clk);
    chk(res_valid && res_index == 4'd2 && !lk_ready, "R9 stalled result", res_addr, 32'h0020_0000);
    lk_addr = 32'h0010_0000;
    @(negedge clk);
    chk(res_valid && res_addr == 32'h0020_0000 && res_hit && res_index == 4'd2 && !lk_ready,
        "R9 hold under stall", res_addr, 32'h0020_0000);
    res_ready = 1'b1;
    #1;
    chk(lk_ready, "R9 ready when consumer ready", 32'(lk_ready), 32'd1);
    @(negedge clk);
    lk_valid = 1'b0;
    chk(res_valid && res_addr == 32'h0010_0000 && res_index == 4'd0, "R9 second accepted",
        res_addr, 32'h0010_0000);

    // R10: clear entry0 low word
    wr(8'h00, 32'h0);
    look('{32'h0010_2000, 1'b1, 4'd5, 1'b1, 10'h3FF, 1'b0}, "R10 cleared entry skipped");
    look('{32'h0010_0000, 1'b0, 4'd0, 1'b0, 10'd0, 1'b0}, "R10 cleared range misses");
    rd_chk(8'h04, 32'h0010_3000, "R10 high word kept");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule